// File: doc/BRIEF.md
# Iterative Floating-Point Mantissa Divider

This core sits inside a single-precision floating-point divide path, between an unpack/pre-normalise stage and a post-normalise/round stage. It takes two unpacked operands, each a sign, an unbiased two's-complement exponent and a 24-bit mantissa whose top bit is already set. It returns an unpacked quotient: a sign, an unbiased exponent difference, a 24-bit mantissa and the guard, round and sticky bits that the rounding stage needs.

The sign and exponent are resolved in the cycle an operation is accepted. The mantissa is produced by a restoring shift-subtract loop, one quotient bit per clock. Before the loop starts, the dividend mantissa is placed 27 positions up inside 51-bit working registers. That extra width holds the guard, round and sticky information, so no exponent bias is applied inside the core. Operands enter over a valid/ready interface. A result leaves as a single-cycle `out_valid` strobe with no back-pressure. The result fields then hold their value until the next operation is accepted, so a consumer that misses the strobe can still read them.

Top module: `fdiv_mant_core`

## Requirements
- R1: `in_ready` is high whenever no division is running. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the cycle after acceptance up to the cycle in which `out_valid` is high, and it is high in that cycle. While `in_ready` is low, `in_valid` and the operand inputs are ignored: they neither change the result nor produce an extra result.
- R2: `out_sign` is the XOR of `a_sign` and `b_sign` of the accepted operation.
- R3: `out_exp` is the 11-bit two's-complement value `a_exp - b_exp`. Both exponents are 10-bit two's-complement inputs. No bias term is added, and the full range -1023..1023 is representable.
- R4: `out_valid` is high for exactly one cycle. It is the 51st cycle after the accepting edge: it rises on the 51st rising edge after that edge and falls on the next one.
- R5: Let Q = floor((a_mant * 2^27) / b_mant). `out_mant` equals bits 27 down to 4 of Q.
- R6: `out_guard` equals bit 3 of Q, and `out_round` equals bit 2 of Q.
- R7: `out_sticky` is 1 exactly when bit 1 or bit 0 of Q is set, or when the division leaves a nonzero remainder.
- R8: From the `out_valid` cycle until the next accepting edge, every result output holds its value.
- R9: While reset (`rst_n` low) is applied, `in_ready` is 1, `out_valid` is 0, and `out_mant` and `out_exp` are 0.
- R10: When `a_mant < b_mant`, Q is below 2^27, so bit 23 of `out_mant` is 0. The mantissa is passed on without any normalising shift.
- R11: A new operation offered in the `out_valid` cycle is accepted on the following edge. That gives back-to-back operation with a 52-cycle issue interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Core idle and able to accept |
| a_sign | input | 1 | Dividend sign |
| a_exp | input | 10 | Dividend exponent, unbiased two's complement |
| a_mant | input | 24 | Dividend mantissa, MSB set |
| b_sign | input | 1 | Divisor sign |
| b_exp | input | 10 | Divisor exponent, unbiased two's complement |
| b_mant | input | 24 | Divisor mantissa, MSB set |
| out_valid | output | 1 | One-cycle result strobe |
| out_sign | output | 1 | Quotient sign |
| out_exp | output | 11 | Exponent difference, two's complement |
| out_mant | output | 24 | Quotient bits 27..4 |
| out_guard | output | 1 | Quotient bit 3 |
| out_round | output | 1 | Quotient bit 2 |
| out_sticky | output | 1 | OR of quotient bits 1..0 and the remainder |

## Verification
Equal mantissas give a quotient of exactly 2^27, which has no guard, round or sticky bits set. That case separates a correct alignment of the mantissa window from a window that is off by one bit. Maximum over minimum sets every retained bit. Minimum over maximum yields an unnormalised quotient with a nonzero remainder, which exercises both the pass-through of a zero MSB and the remainder's contribution to sticky. Random normalised mantissas with random and extreme exponents, issued back to back, test the quotient bits, the sign XOR and the exponent subtraction without overflow. Operands offered while the core is busy show whether ignored input leaks into a result.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int unsigned MANT_W_DEF = 24;
  localparam int unsigned SHIFT_DEF  = 27;
  localparam int unsigned EXP_W_DEF  = 10;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl
  import fdiv_pkg::*;
#(
  parameter int unsigned STEPS = 51
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic accept,
  output logic step,
  output logic out_valid
);
  localparam int unsigned CNT_W = $clog2(STEPS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  run_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign step     = (state_q == ST_RUN);
  assign out_valid = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  // R1: acceptance closes the input side on the next cycle
  p_accept_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R1, R11: the result cycle is also an accepting cycle
  p_ready_at_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  // R4: result strobe lasts a single cycle
  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R4: counter never runs past the last step
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt_q <= LAST));
endmodule

// File: rtl/fdiv_sign_exp.sv
module fdiv_sign_exp #(
  parameter int unsigned EXP_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             a_sign,
  input  logic             b_sign,
  input  logic [EXP_W-1:0] a_exp,
  input  logic [EXP_W-1:0] b_exp,
  output logic             out_sign,
  output logic [EXP_W:0]   out_exp
);
  localparam int unsigned DIF_W = EXP_W + 1;

  logic [DIF_W-1:0] a_ext, b_ext;
  assign a_ext = {a_exp[EXP_W-1], a_exp};
  assign b_ext = {b_exp[EXP_W-1], b_exp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sign <= 1'b0;
      out_exp  <= '0;
    end else if (load) begin
      out_sign <= a_sign ^ b_sign;
      out_exp  <= a_ext - b_ext;
    end
  end

  // R2: quotient sign follows operand signs
  p_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (out_sign != ($past(a_sign) == $past(b_sign))));

  // R3: adding the divisor exponent back recovers the dividend exponent
  p_exp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (DIF_W'(out_exp + $past(b_ext)) == $past(a_ext)));
endmodule

// File: rtl/fdiv_step.sv
module fdiv_step #(
  parameter int unsigned W = 51
) (
  input  logic [W-1:0] rem,
  input  logic         next_bit,
  input  logic [W-1:0] div,
  output logic [W-1:0] rem_nxt,
  output logic         qbit
);
  logic [W:0]   widened;
  logic [W-1:0] diff;

  always_comb begin
    widened = {rem, next_bit};
    diff    = widened[W-1:0] - div;
    qbit    = (widened >= {1'b0, div});
    rem_nxt = qbit ? diff : widened[W-1:0];
  end
endmodule

// File: rtl/fdiv_pack.sv
module fdiv_pack #(
  parameter int unsigned MANT_W = 24,
  parameter int unsigned SHIFT  = 27,
  parameter int unsigned W      = 51
) (
  input  logic [SHIFT+1:0]  quo,
  input  logic [W-1:0]      rem,
  output logic [MANT_W-1:0] mant,
  output logic              guard,
  output logic              round,
  output logic              sticky
);
  localparam int unsigned LOW = SHIFT - MANT_W + 1;

  always_comb begin
    mant   = quo[SHIFT:LOW];
    guard  = quo[LOW-1];
    round  = quo[LOW-2];
    sticky = (|quo[LOW-3:0]) | (|rem);
  end
endmodule

// File: rtl/fdiv_mant_core.sv
module fdiv_mant_core
  import fdiv_pkg::*;
#(
  parameter int unsigned MANT_W = MANT_W_DEF,
  parameter int unsigned SHIFT  = SHIFT_DEF,
  parameter int unsigned EXP_W  = EXP_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              a_sign,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [MANT_W-1:0] a_mant,
  input  logic              b_sign,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [MANT_W-1:0] b_mant,
  output logic              out_valid,
  output logic              out_sign,
  output logic [EXP_W:0]    out_exp,
  output logic [MANT_W-1:0] out_mant,
  output logic              out_guard,
  output logic              out_round,
  output logic              out_sticky
);
  localparam int unsigned WORK_W = MANT_W + SHIFT;
  localparam int unsigned QUO_W  = SHIFT + 2;

  logic accept, step;
  logic [WORK_W-1:0] dvd_q, div_q, quo_q, rem_q;
  logic [WORK_W-1:0] rem_nxt;
  logic              qbit;

  fdiv_ctrl #(.STEPS(WORK_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .accept(accept), .step(step), .out_valid(out_valid)
  );

  fdiv_sign_exp #(.EXP_W(EXP_W)) u_sexp (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .a_sign(a_sign), .b_sign(b_sign), .a_exp(a_exp), .b_exp(b_exp),
    .out_sign(out_sign), .out_exp(out_exp)
  );

  fdiv_step #(.W(WORK_W)) u_step (
    .rem(rem_q), .next_bit(dvd_q[WORK_W-1]), .div(div_q),
    .rem_nxt(rem_nxt), .qbit(qbit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q <= '0;
      div_q <= '0;
      quo_q <= '0;
      rem_q <= '0;
    end else if (accept) begin
      dvd_q <= WORK_W'(a_mant) << SHIFT;
      div_q <= WORK_W'(b_mant);
      quo_q <= '0;
      rem_q <= '0;
    end else if (step) begin
      dvd_q <= dvd_q << 1;
      rem_q <= rem_nxt;
      quo_q <= {quo_q[WORK_W-2:0], qbit};
    end
  end

  fdiv_pack #(.MANT_W(MANT_W), .SHIFT(SHIFT), .W(WORK_W)) u_pack (
    .quo(quo_q[QUO_W-1:0]), .rem(rem_q),
    .mant(out_mant), .guard(out_guard), .round(out_round), .sticky(out_sticky)
  );

  // R7: restoring invariant, the partial remainder stays below the divisor
  p_rem_below_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && div_q[MANT_W-1]) |-> (rem_q < div_q));

  // R5: with normalised operands the quotient fits the retained window
  p_quo_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && div_q[MANT_W-1]) |-> (quo_q[WORK_W-1:QUO_W] == '0));

  // R8: idle without a new operation keeps every result field
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> ($stable(out_mant) && $stable(out_exp) &&
      $stable(out_sign) && $stable(out_guard) && $stable(out_round) &&
      $stable(out_sticky)));
endmodule

// File: tb/fdiv_mant_core_tb_top.sv
module fdiv_mant_core_tb_top;
  typedef struct {
    logic        s;
    logic [10:0] e;
    logic [23:0] m;
    logic        g;
    logic        r;
    logic        st;
    int          acc;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic a_sign = 1'b0, b_sign = 1'b0;
  logic [9:0] a_exp = '0, b_exp = '0;
  logic [23:0] a_mant = '0, b_mant = '0;
  logic out_valid, out_sign, out_guard, out_round, out_sticky;
  logic [10:0] out_exp;
  logic [23:0] out_mant;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int n_sent = 0;
  int n_got = 0;
  exp_t sb[$];
  exp_t last_res;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fdiv_mant_core dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
    .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
    .out_mant(out_mant), .out_guard(out_guard), .out_round(out_round),
    .out_sticky(out_sticky)
  );

  task automatic chk(input string req, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic exp_t model(input logic as, input logic [9:0] ae,
                                 input logic [23:0] am, input logic bs,
                                 input logic [9:0] be, input logic [23:0] bm);
    exp_t x;
    logic [63:0] num, q, rm;
    num  = 64'(am) << 27;
    q    = num / 64'(bm);
    rm   = num % 64'(bm);
    x.s  = as ^ bs;
    x.e  = {ae[9], ae} - {be[9], be};
    x.m  = q[27:4];
    x.g  = q[3];
    x.r  = q[2];
    x.st = (|q[1:0]) || (rm != 0);
    x.acc = 0;
    return x;
  endfunction

  task automatic send(input logic as, input logic [9:0] ae, input logic [23:0] am,
                      input logic bs, input logic [9:0] be, input logic [23:0] bm,
                      input bit poke_busy);
    exp_t x;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    a_sign = as; a_exp = ae; a_mant = am;
    b_sign = bs; b_exp = be; b_mant = bm;
    in_valid = 1'b1;
    x = model(as, ae, am, bs, be, bm);
    x.acc = cyc + 1;
    sb.push_back(x);
    n_sent++;
    @(negedge clk);
    if (poke_busy) begin
      for (int k = 0; k < 3; k++) begin
        a_sign = ~as; a_exp = ~ae; a_mant = 24'hC00001 + 24'(k);
        b_mant = 24'h812345; b_exp = 10'h155;
        chk("R1 in_ready low while busy", longint'(in_ready), 0);
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
  endtask

  // scoreboard monitor
  initial begin
    logic prev_ov;
    exp_t x;
    prev_ov = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        chk("R4 single-cycle strobe", longint'(prev_ov), 0);
        if (sb.size() == 0) begin
          chk("R1 no unexpected result", 1, 0);
        end else begin
          x = sb.pop_front();
          n_got++;
          chk("R4 latency", longint'(cyc - x.acc), 51);
          chk("R2 sign", longint'(out_sign), longint'(x.s));
          chk("R3 exponent", longint'(out_exp), longint'(x.e));
          chk("R5 mantissa", longint'(out_mant), longint'(x.m));
          chk("R6 guard", longint'(out_guard), longint'(x.g));
          chk("R6 round", longint'(out_round), longint'(x.r));
          chk("R7 sticky", longint'(out_sticky), longint'(x.st));
          chk("R11 ready in result cycle", longint'(in_ready), 1);
          last_res = x;
        end
      end
      prev_ov = rst_n && out_valid;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_got, n_sent);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 in_ready in reset", longint'(in_ready), 1);
    chk("R9 out_valid in reset", longint'(out_valid), 0);
    chk("R9 out_mant in reset", longint'(out_mant), 0);
    chk("R9 out_exp in reset", longint'(out_exp), 0);
    rst_n = 1'b1;

    // equal mantissas: Q = 2^27 exactly
    send(1'b0, 10'd5, 24'h800000, 1'b0, 10'd5, 24'h800000, 1'b0);
    send(1'b1, 10'd0, 24'hFFFFFF, 1'b0, 10'd1, 24'hFFFFFF, 1'b0);
    // max over min
    send(1'b0, 10'd127, 24'hFFFFFF, 1'b1, 10'h382, 24'h800000, 1'b0);
    // min over max: unnormalised quotient, R10
    send(1'b1, 10'h200, 24'h800000, 1'b1, 10'h1FF, 24'hFFFFFF, 1'b0);
    wait (sb.size() == 0);
    @(negedge clk);
    chk("R10 quotient MSB passed as zero", longint'(out_mant[23]), 0);
    chk("R3 extreme negative exponent", longint'(out_exp), longint'(11'h401));

    // R8: outputs hold while idle
    e = last_res;
    repeat (6) @(negedge clk);
    chk("R8 mantissa held", longint'(out_mant), longint'(e.m));
    chk("R8 exponent held", longint'(out_exp), longint'(e.e));
    chk("R8 sticky held", longint'(out_sticky), longint'(e.st));

    // R1: operands offered while busy are ignored
    send(1'b0, 10'd3, 24'hA5A5A5, 1'b1, 10'd9, 24'hC3C3C3, 1'b1);

    // random, back to back (R11)
    for (int i = 0; i < 40; i++) begin
      send(1'($urandom), 10'($urandom), {1'b1, 23'($urandom)},
           1'($urandom), 10'($urandom), {1'b1, 23'($urandom)}, 1'b0);
    end
    wait (sb.size() == 0);
    repeat (4) @(negedge clk);
    chk("R1 result count", longint'(n_got), longint'(n_sent));
    chk("R4 strobe low after drain", longint'(out_valid), 0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule